// File: doc/BRIEF.md
# Load-Linked Unit with Alignment Check

This block executes the load half of an atomic read-modify-write pair. A request carries a virtual address, an access size (word or doubleword), the core's debug-mode flag and the physical address already produced by an external translation stage. The block first tests the virtual address for natural alignment. A misaligned request raises an address-error-on-load exception and never reaches memory. An aligned request becomes exactly one read on a simple request/response memory port.

When the read data returns, the block formats it. A word is sign-extended from bit 31 and a doubleword passes through unchanged. The formatted value is returned as the result. The block also records the link state that a later store-conditional will compare against: the physical address, the virtual address and the loaded value. On a fault, the bad-virtual-address register captures the faulting address, but only when the core is not in debug mode.

Top module: `ll_unit`

## Requirements
- R1: A word request (`req_dword_i`=0) is misaligned exactly when `req_vaddr_i[1:0]` is non-zero. An address with only bit 2 set among bits [2:0] is aligned for a word.
- R2: A doubleword request (`req_dword_i`=1) is misaligned exactly when `req_vaddr_i[2:0]` is non-zero.
- R3: On a misaligned request with `req_debug_i`=0, `badvaddr_o` holds the request's virtual address from the cycle after acceptance. With `req_debug_i`=1, `badvaddr_o` keeps its previous value.
- R4: A misaligned request pulses `exc_adel_o` for exactly one cycle, in the cycle after acceptance. It asserts no `mem_req_o`, produces no `res_valid_o`, and leaves all link registers unchanged.
- R5: An aligned request drives `mem_req_o` high for exactly one cycle, in the cycle after acceptance, with `mem_addr_o` equal to the accepted physical address and `mem_dword_o` equal to the accepted size.
- R6: When the read completes, `link_paddr_o` takes the accepted physical address and `link_vaddr_o` takes the accepted virtual address.
- R7: When the read completes, `link_val_o` and `res_data_o` both hold the formatted loaded value.
- R8: For a word load the result is `mem_rdata_i[31:0]` sign-extended from bit 31 to XLEN bits, and `mem_rdata_i[63:32]` has no effect. For a doubleword load the result is `mem_rdata_i` unchanged.
- R9: `req_ready_o` is high only while no read is outstanding, and a request presented while it is low is ignored. `res_valid_o` pulses for one cycle, in the cycle after the edge at which `mem_rvalid_i` is sampled high.
- R10: Reset clears the link registers, `badvaddr_o`, `exc_adel_o`, `res_valid_o` and `mem_req_o`, and leaves `req_ready_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Load-linked request valid |
| req_ready_o | output | 1 | Unit idle and able to accept a request |
| req_dword_i | input | 1 | Access size: 0 word, 1 doubleword |
| req_vaddr_i | input | XLEN | Virtual address |
| req_debug_i | input | 1 | Core is in debug mode |
| req_paddr_i | input | PA_W | Translated physical address, valid with the request |
| mem_req_o | output | 1 | Read request to memory |
| mem_addr_o | output | PA_W | Read physical address |
| mem_dword_o | output | 1 | Read size: 0 word, 1 doubleword |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | XLEN | Read data; a word is in bits [31:0] |
| res_valid_o | output | 1 | Result valid pulse |
| res_data_o | output | XLEN | Formatted load result |
| exc_adel_o | output | 1 | Address-error-on-load pulse |
| badvaddr_o | output | XLEN | Bad virtual address register |
| link_paddr_o | output | PA_W | Link physical address |
| link_vaddr_o | output | XLEN | Link virtual address |
| link_val_o | output | XLEN | Link value |

## Verification
Each result has a fixed due cycle after acceptance. For an aligned request, `mem_req_o` is due in the first cycle after acceptance. The result and the link registers are due in the first cycle after the edge that samples `mem_rvalid_i`. For a misaligned request, `exc_adel_o` and `badvaddr_o` are due in the first cycle after acceptance. The bench drives inputs on the falling edge and samples outputs at those exact falling edges. It also samples one cycle later to confirm each pulse has dropped. It sweeps every combination of size, low address bits and debug mode, with several memory latencies and both signs of data.

// File: rtl/ll_pkg.sv
package ll_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2
  } ll_state_e;

  localparam int unsigned WORD_BITS = 32;
endpackage

// File: rtl/ll_align_chk.sv
module ll_align_chk (
  input  logic [2:0] addr_lo_i,
  input  logic       dword_i,
  output logic       misaligned_o
);
  localparam logic [2:0] WORD_MASK  = 3'b011;
  localparam logic [2:0] DWORD_MASK = 3'b111;

  logic [2:0] mask;

  always_comb begin
    mask         = dword_i ? DWORD_MASK : WORD_MASK;
    misaligned_o = |(addr_lo_i & mask);
  end
endmodule

// File: rtl/ll_result_fmt.sv
module ll_result_fmt #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] raw_i,
  input  logic            dword_i,
  output logic [XLEN-1:0] data_o
);
  localparam int unsigned WB = ll_pkg::WORD_BITS;

  generate
    if (XLEN > WB) begin : g_wide
      logic [XLEN-1:0] word_ext;
      always_comb begin
        word_ext = {{(XLEN-WB){raw_i[WB-1]}}, raw_i[WB-1:0]};
        data_o   = dword_i ? raw_i : word_ext;
      end
    end else begin : g_narrow
      logic unused_dw;
      assign unused_dw = dword_i;
      assign data_o    = raw_i;
    end
  endgenerate
endmodule

// File: rtl/ll_fault_regs.sv
module ll_fault_regs #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fault_i,
  input  logic            debug_i,
  input  logic [XLEN-1:0] vaddr_i,
  output logic            exc_o,
  output logic [XLEN-1:0] badvaddr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_o      <= 1'b0;
      badvaddr_o <= '0;
    end else begin
      exc_o <= fault_i;
      if (fault_i && !debug_i) badvaddr_o <= vaddr_i;
    end
  end

  p_bad_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i && !debug_i) |=> (badvaddr_o == $past(vaddr_i)));

  p_bad_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i && debug_i) |=> $stable(badvaddr_o));

  p_exc_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_o && !fault_i) |=> !exc_o);
endmodule

// File: rtl/ll_link_regs.sv
module ll_link_regs #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned PA_W = 40
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            upd_i,
  input  logic [PA_W-1:0] paddr_i,
  input  logic [XLEN-1:0] vaddr_i,
  input  logic [XLEN-1:0] val_i,
  output logic [PA_W-1:0] link_paddr_o,
  output logic [XLEN-1:0] link_vaddr_o,
  output logic [XLEN-1:0] link_val_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_paddr_o <= '0;
      link_vaddr_o <= '0;
      link_val_o   <= '0;
    end else if (upd_i) begin
      link_paddr_o <= paddr_i;
      link_vaddr_o <= vaddr_i;
      link_val_o   <= val_i;
    end
  end
endmodule

// File: rtl/ll_unit.sv
module ll_unit #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned PA_W = 40
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            req_dword_i,
  input  logic [XLEN-1:0] req_vaddr_i,
  input  logic            req_debug_i,
  input  logic [PA_W-1:0] req_paddr_i,
  output logic            mem_req_o,
  output logic [PA_W-1:0] mem_addr_o,
  output logic            mem_dword_o,
  input  logic            mem_rvalid_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            res_valid_o,
  output logic [XLEN-1:0] res_data_o,
  output logic            exc_adel_o,
  output logic [XLEN-1:0] badvaddr_o,
  output logic [PA_W-1:0] link_paddr_o,
  output logic [XLEN-1:0] link_vaddr_o,
  output logic [XLEN-1:0] link_val_o
);
  import ll_pkg::*;

  ll_state_e       state_q, state_d;
  logic [PA_W-1:0] pa_q;
  logic [XLEN-1:0] va_q;
  logic            dw_q;
  logic            accept, misaligned, fault, good, done;
  logic [XLEN-1:0] fmt_data;
  logic            res_valid_q;
  logic [XLEN-1:0] res_data_q;

  assign req_ready_o = (state_q == S_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  ll_align_chk u_align (
    .addr_lo_i    (req_vaddr_i[2:0]),
    .dword_i      (req_dword_i),
    .misaligned_o (misaligned)
  );

  assign fault = accept && misaligned;
  assign good  = accept && !misaligned;
  assign done  = (state_q == S_WAIT) && mem_rvalid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (good) state_d = S_ISSUE;
      S_ISSUE: state_d = S_WAIT;
      S_WAIT:  if (mem_rvalid_i) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pa_q    <= '0;
      va_q    <= '0;
      dw_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (good) begin
        pa_q <= req_paddr_i;
        va_q <= req_vaddr_i;
        dw_q <= req_dword_i;
      end
    end
  end

  assign mem_req_o   = (state_q == S_ISSUE);
  assign mem_addr_o  = pa_q;
  assign mem_dword_o = dw_q;

  ll_result_fmt #(.XLEN(XLEN)) u_fmt (
    .raw_i   (mem_rdata_i),
    .dword_i (dw_q),
    .data_o  (fmt_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q <= 1'b0;
      res_data_q  <= '0;
    end else begin
      res_valid_q <= done;
      if (done) res_data_q <= fmt_data;
    end
  end

  assign res_valid_o = res_valid_q;
  assign res_data_o  = res_data_q;

  ll_link_regs #(.XLEN(XLEN), .PA_W(PA_W)) u_link (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .upd_i        (done),
    .paddr_i      (pa_q),
    .vaddr_i      (va_q),
    .val_i        (fmt_data),
    .link_paddr_o (link_paddr_o),
    .link_vaddr_o (link_vaddr_o),
    .link_val_o   (link_val_o)
  );

  ll_fault_regs #(.XLEN(XLEN)) u_fault (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fault_i    (fault),
    .debug_i    (req_debug_i),
    .vaddr_i    (req_vaddr_i),
    .exc_o      (exc_adel_o),
    .badvaddr_o (badvaddr_o)
  );

  p_fault_no_mem_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault |=> (exc_adel_o && !mem_req_o && !res_valid_o));

  p_fault_link_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault |=> ($stable(link_paddr_o) && $stable(link_vaddr_o) && $stable(link_val_o)));

  p_issue_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good |=> (mem_req_o && mem_addr_o == $past(req_paddr_i) && mem_dword_o == $past(req_dword_i)));

  p_req_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  p_link_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (link_paddr_o == mem_addr_o && link_vaddr_o == va_q));

  p_link_val_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (link_val_o == res_data_o));

  p_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  p_res_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  generate
    if (XLEN > WORD_BITS) begin : g_sext_chk
      p_sext_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_valid_o && !dw_q) |->
          (res_data_o[XLEN-1:WORD_BITS-1] == '0 || res_data_o[XLEN-1:WORD_BITS-1] == '1));
    end
  endgenerate
endmodule

// File: tb/tb_ll_unit.sv
`timescale 1ns/1ps
module tb_ll_unit;
  localparam int unsigned XLEN = 64;
  localparam int unsigned PA_W = 40;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            req_valid_i = 1'b0;
  logic            req_ready_o;
  logic            req_dword_i = 1'b0;
  logic [XLEN-1:0] req_vaddr_i = '0;
  logic            req_debug_i = 1'b0;
  logic [PA_W-1:0] req_paddr_i = '0;
  logic            mem_req_o;
  logic [PA_W-1:0] mem_addr_o;
  logic            mem_dword_o;
  logic            mem_rvalid_i = 1'b0;
  logic [XLEN-1:0] mem_rdata_i = '0;
  logic            res_valid_o;
  logic [XLEN-1:0] res_data_o;
  logic            exc_adel_o;
  logic [XLEN-1:0] badvaddr_o;
  logic [PA_W-1:0] link_paddr_o;
  logic [XLEN-1:0] link_vaddr_o;
  logic [XLEN-1:0] link_val_o;

  always #2.5 clk_i = ~clk_i;

  ll_unit #(.XLEN(XLEN), .PA_W(PA_W)) dut (.*);

  int total = 0;
  int bad = 0;
  logic [XLEN-1:0] e_bad = '0, e_lva = '0, e_lval = '0;
  logic [PA_W-1:0] e_lpa = '0;

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_links(input string req);
    chk(req, XLEN'(link_paddr_o), XLEN'(e_lpa));
    chk(req, link_vaddr_o, e_lva);
    chk(req, link_val_o, e_lval);
  endtask

  task automatic do_ll(input logic dw, input logic [XLEN-1:0] va, input logic [PA_W-1:0] pa,
                       input logic dbg, input logic [XLEN-1:0] rd, input int lat);
    logic mis;
    logic [XLEN-1:0] exp;
    mis = dw ? (va[2:0] != 3'd0) : (va[1:0] != 2'd0);
    @(negedge clk_i);
    chk("R9 ready idle", XLEN'(req_ready_o), 1);
    req_valid_i = 1'b1; req_dword_i = dw; req_vaddr_i = va;
    req_paddr_i = pa;   req_debug_i = dbg;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (mis) begin
      if (!dbg) e_bad = va;
      chk(dw ? "R2 exc" : "R1 exc", XLEN'(exc_adel_o), 1);
      chk("R4 no mem", XLEN'(mem_req_o), 0);
      chk("R3 badvaddr", badvaddr_o, e_bad);
      @(negedge clk_i);
      chk("R4 exc pulse", XLEN'(exc_adel_o), 0);
      chk("R4 no mem late", XLEN'(mem_req_o), 0);
      chk("R4 no res", XLEN'(res_valid_o), 0);
      chk_links("R4 links kept");
    end else begin
      chk(dw ? "R2 no exc" : "R1 no exc", XLEN'(exc_adel_o), 0);
      chk("R5 mem_req", XLEN'(mem_req_o), 1);
      chk("R5 mem_addr", XLEN'(mem_addr_o), XLEN'(pa));
      chk("R5 mem_dword", XLEN'(mem_dword_o), XLEN'(dw));
      chk("R9 busy", XLEN'(req_ready_o), 0);
      // ignored request while busy
      req_valid_i = 1'b1; req_vaddr_i = 64'h1; req_paddr_i = '1;
      for (int i = 0; i < lat; i++) begin
        @(negedge clk_i);
        chk("R5 req one cycle", XLEN'(mem_req_o), 0);
        chk("R9 no early res", XLEN'(res_valid_o), 0);
        chk("R9 busy ignore", XLEN'(exc_adel_o), 0);
      end
      req_valid_i = 1'b0;
      mem_rvalid_i = 1'b1; mem_rdata_i = rd;
      @(negedge clk_i);
      mem_rvalid_i = 1'b0; mem_rdata_i = '0;
      if (dw) exp = rd;
      else if (rd[31]) exp = {32'hFFFF_FFFF, rd[31:0]};
      else exp = {32'h0, rd[31:0]};
      e_lpa = pa; e_lva = va; e_lval = exp;
      chk("R9 res_valid", XLEN'(res_valid_o), 1);
      chk("R8 res_data", res_data_o, exp);
      chk("R7 link_val", link_val_o, exp);
      chk_links("R6 links");
      chk("R9 ready back", XLEN'(req_ready_o), 1);
      @(negedge clk_i);
      chk("R9 res pulse", XLEN'(res_valid_o), 0);
      chk("R9 busy req ignored", XLEN'(mem_req_o), 0);
    end
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R10 link", XLEN'(link_paddr_o), 0);
    chk("R10 lva", link_vaddr_o, 0);
    chk("R10 lval", link_val_o, 0);
    chk("R10 bad", badvaddr_o, 0);
    chk("R10 exc", XLEN'(exc_adel_o), 0);
    chk("R10 res", XLEN'(res_valid_o), 0);
    chk("R10 memreq", XLEN'(mem_req_o), 0);
    chk("R10 ready", XLEN'(req_ready_o), 1);
    rst_ni = 1'b1;
    for (int dw = 0; dw < 2; dw++)
      for (int lo = 0; lo < 8; lo++)
        for (int dbg = 0; dbg < 2; dbg++) begin
          logic [XLEN-1:0] va, rd;
          logic [PA_W-1:0] pa;
          va = 64'h0000_4000_1230_0000 | XLEN'(lo) | (XLEN'(dw * 2 + dbg) << 8);
          pa = 40'h12_3450_0000 | PA_W'(lo) | (PA_W'(dw * 16 + dbg) << 12);
          rd = ((lo + dbg) % 2 == 0) ? 64'hDEAD_BEEF_8765_4321 : 64'h8123_4567_1357_9BDF;
          do_ll(dw[0], va, pa, dbg[0], rd, 1 + (lo % 3));
        end
    @(negedge clk_i);
    chk("R10 final bad kept", badvaddr_o, e_bad);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule